// File: doc/BRIEF.md
# Repeated-Primitive Run Suppressor

This block sits on the 32-bit dword paths of a serial link layer, one instance per link, between the framing logic and the physical coding layer. On the transmit side it watches for a primitive that repeats. When the same primitive shows up in three consecutive cycles, the third copy is replaced by a continuation primitive. Every later copy in the same run is replaced by a pseudo-random filler dword that carries no K flag. The filler comes from an internal 16-bit LFSR. This cuts the number of repeated control symbols on the line.

On the receive side it reverses the substitution. It remembers the last ordinary primitive it received. After a continuation primitive arrives, it puts that remembered primitive in place of every dword until a new primitive ends the continuation. A HOLD received while a continuation is active wipes the transmit history, so that the transmit side must build up a fresh run.

Both directions take one dword per cycle and have a fixed latency of one cycle through a registered output. Each dword comes with a single K flag, and K=1 marks a primitive. The continuation, HOLD, ALIGN and idle primitive codes are parameters.

Top module: `rpt_prim_squash`

## Requirements
- R1: While `rst` is high, both outputs drive data 0 with K=0.
- R2: On transmit, a data dword (K=0) or the ALIGN code (`PRIM_ALIGN`, K=1) appears unchanged at the output one cycle later. It never counts toward a run, and a run is broken by it.
- R3: A transmit primitive other than ALIGN that is equal to the primitive input in each of the two previous cycles is output one cycle later as `PRIM_CONT` with K=1, provided the run counter is zero. A primitive with fewer than two equal predecessors passes unchanged.
- R4: Each further copy of the same run is output as a filler dword with K=0. Fillers are successive 32-bit words of the LFSR x^16+x^15+x^13+x^4+1 (shift left, feedback = XOR of state bits 15, 14, 12 and 3), seeded with 16'hF0F6. Bit i of a word is state bit 15 before shift i, for i = 0 to 31. The first filler of every run is the first word from the seed.
- R5: Any dword that breaks a run passes unchanged and clears the run counter. A later run therefore starts again with `PRIM_CONT`, and its fillers restart from the seed.
- R6: On receive, a primitive other than `PRIM_CONT` and ALIGN passes unchanged one cycle later. It clears the continue flag and becomes the remembered primitive.
- R7: On receive, `PRIM_CONT` sets the continue flag and is itself output as the remembered primitive with K=1. While the flag is set, each data dword is output as the remembered primitive with K=1. After reset the remembered primitive is `PRIM_IDLE`.
- R8: On receive, ALIGN passes unchanged and alters neither the continue flag nor the remembered primitive.
- R9: On receive, a data dword that arrives with the continue flag clear passes unchanged with K=0.
- R10: A received `PRIM_HOLD` that arrives while the continue flag is set clears the transmit history. The transmit dword of that same cycle is judged against an empty history, so a run can complete no earlier than the third identical primitive counted from that dword. A HOLD that arrives with the flag clear has no such effect.
- R11: The run counter saturates at its maximum. A run longer than the counter range keeps emitting successive fillers and never emits a second `PRIM_CONT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_data | input | DATA_W | Transmit dword from framing |
| tx_in_k | input | 1 | Transmit K flag (1 = primitive) |
| tx_out_data | output | DATA_W | Transmit dword toward the line |
| tx_out_k | output | 1 | Transmit output K flag |
| rx_in_data | input | DATA_W | Received dword from the line |
| rx_in_k | input | 1 | Received K flag |
| rx_out_data | output | DATA_W | Received dword after run expansion |
| rx_out_k | output | 1 | Received output K flag |

## Verification
The bench builds the block with `CNT_W` = 2, keeping every other parameter at its default. With a 2-bit counter, saturation is reached after only three fillers, so a run of nine copies shows that the block never emits a second continuation primitive and that the fillers keep advancing past the counter limit. The default primitive codes and the LFSR seed are kept, so the filler words are checked against the generator as it is specified. Stimulus interleaves receive continuations with HOLD at different counter values, which exercises the history wipe in the middle of a run as well as the ignored case where the flag is clear.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;
  // What the transmit side puts on the line for the current input dword.
  typedef enum logic [1:0] {
    EMIT_PASS = 2'd0,
    EMIT_CONT = 2'd1,
    EMIT_FILL = 2'd2
  } emit_e;
endpackage

// File: rtl/rps_lfsr.sv
`timescale 1ns/1ps
// Filler generator: a Fibonacci LFSR that advances DATA_W steps per word.
module rps_lfsr #(
  parameter int              LFSR_W = 16,
  parameter int              DATA_W = 32,
  parameter logic [LFSR_W-1:0] TAPS = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED = 16'hF0F6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic              step,
  output logic [DATA_W-1:0] word_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] walk;

  // Unrolled walk: word bit i is the top state bit before shift i.
  always_comb begin
    walk   = state_q;
    word_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      word_o[i] = walk[LFSR_W-1];
      walk      = {walk[LFSR_W-2:0], ^(walk & TAPS)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || reload) state_q <= SEED;
    else if (step)     state_q <= walk;
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    reload |=> (state_q == SEED)); // R5

endmodule

// File: rtl/rps_tx_squash.sv
`timescale 1ns/1ps
// Transmit side: detects runs of identical primitives and replaces them.
module rps_tx_squash
  import rps_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                CNT_W   = 8,
  parameter logic [DATA_W-1:0] P_ALIGN = 32'h7B4A4ABC,
  parameter logic [DATA_W-1:0] P_CONT  = 32'h9999AA7C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hist_clr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_k,
  input  logic [DATA_W-1:0] fill_word,
  output logic              fill_step,
  output logic              fill_reload,
  output logic [DATA_W-1:0] out_data,
  output logic              out_k
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] h0_d, h1_d;   // h0: previous cycle, h1: two cycles back
  logic              h0_v, h1_v;   // entry holds a countable primitive
  logic [CNT_W-1:0]  cnt_q;
  logic              countable, h0_ok, h1_ok, run;
  emit_e             emit;

  always_comb begin
    countable   = in_k && (in_data != P_ALIGN);
    h0_ok       = h0_v && !hist_clr;
    h1_ok       = h1_v && !hist_clr;
    run         = countable && h0_ok && h1_ok && (h0_d == in_data) && (h1_d == in_data);
    if (!run)              emit = EMIT_PASS;
    else if (cnt_q == '0)  emit = EMIT_CONT;
    else                   emit = EMIT_FILL;
    fill_step   = (emit == EMIT_FILL);
    fill_reload = !run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h0_d     <= '0;
      h0_v     <= 1'b0;
      h1_d     <= '0;
      h1_v     <= 1'b0;
      cnt_q    <= '0;
      out_data <= '0;
      out_k    <= 1'b0;
    end else begin
      h1_d <= h0_d;
      h1_v <= h0_v && !hist_clr;
      h0_d <= in_data;
      h0_v <= countable;
      if (!run)                 cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      case (emit)
        EMIT_CONT: begin out_data <= P_CONT;    out_k <= 1'b1; end
        EMIT_FILL: begin out_data <= fill_word; out_k <= 1'b0; end
        default:   begin out_data <= in_data;   out_k <= in_k; end
      endcase
    end
  end

  AST_TX_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    !in_k |=> (!out_k && out_data == $past(in_data))); // R2

  AST_TX_SHORT_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_k && !(h0_v && h0_d == in_data)) |=> (out_k && out_data == $past(in_data))); // R5

  AST_TX_HIST_WIPE: assert property (@(posedge clk) disable iff (rst)
    hist_clr |=> !h1_v); // R10

  AST_TX_FILL_NOK: assert property (@(posedge clk) disable iff (rst)
    fill_step |=> !out_k); // R4

  AST_TX_SAT_NO_CONT: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == CNT_MAX) |=> (out_data != P_CONT || out_k == 1'b0)); // R11

endmodule

// File: rtl/rps_rx_expand.sv
`timescale 1ns/1ps
// Receive side: replays the remembered primitive while a continuation is active.
module rps_rx_expand #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] P_ALIGN = 32'h7B4A4ABC,
  parameter logic [DATA_W-1:0] P_CONT  = 32'h9999AA7C,
  parameter logic [DATA_W-1:0] P_HOLD  = 32'hD5D5AA7C,
  parameter logic [DATA_W-1:0] P_IDLE  = 32'hB5B5957C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_k,
  output logic              hist_clr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_k
);
  logic              cont_q;
  logic [DATA_W-1:0] last_q;
  logic              is_cont, is_align, is_other;

  always_comb begin
    is_cont  = in_k && (in_data == P_CONT);
    is_align = in_k && (in_data == P_ALIGN);
    is_other = in_k && !is_cont && !is_align;
    hist_clr = cont_q && in_k && (in_data == P_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q   <= 1'b0;
      last_q   <= P_IDLE;
      out_data <= '0;
      out_k    <= 1'b0;
    end else begin
      if (is_cont) begin
        cont_q <= 1'b1;
      end else if (is_other) begin
        cont_q <= 1'b0;
        last_q <= in_data;
      end
      if (is_cont || (!in_k && cont_q)) begin
        out_data <= last_q;
        out_k    <= 1'b1;
      end else begin
        out_data <= in_data;
        out_k    <= in_k;
      end
    end
  end

  AST_RX_CONT_REPLAY: assert property (@(posedge clk) disable iff (rst)
    is_cont |=> (out_k && out_data == last_q)); // R7

  AST_RX_PRIM_PASS: assert property (@(posedge clk) disable iff (rst)
    is_other |=> (out_k && out_data == $past(in_data) && !cont_q)); // R6

  AST_RX_ALIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
    is_align |=> (cont_q == $past(cont_q) && last_q == $past(last_q))); // R8

  AST_RX_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    (!in_k && !cont_q) |=> (!out_k && out_data == $past(in_data))); // R9

endmodule

// File: rtl/rpt_prim_squash.sv
`timescale 1ns/1ps
module rpt_prim_squash #(
  parameter int                DATA_W     = 32,
  parameter int                LFSR_W     = 16,
  parameter int                CNT_W      = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hD008,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 16'hF0F6,
  parameter logic [DATA_W-1:0] PRIM_ALIGN = 32'h7B4A4ABC,
  parameter logic [DATA_W-1:0] PRIM_CONT  = 32'h9999AA7C,
  parameter logic [DATA_W-1:0] PRIM_HOLD  = 32'hD5D5AA7C,
  parameter logic [DATA_W-1:0] PRIM_IDLE  = 32'hB5B5957C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_in_data,
  input  logic              tx_in_k,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_out_k,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic              rx_in_k,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_k
);
  logic              hist_clr;
  logic              fill_step, fill_reload;
  logic [DATA_W-1:0] fill_word;

  rps_lfsr #(
    .LFSR_W (LFSR_W),
    .DATA_W (DATA_W),
    .TAPS   (LFSR_TAPS),
    .SEED   (LFSR_SEED)
  ) u_fill (
    .clk    (clk),
    .rst    (rst),
    .reload (fill_reload),
    .step   (fill_step),
    .word_o (fill_word)
  );

  rps_tx_squash #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .P_ALIGN (PRIM_ALIGN),
    .P_CONT  (PRIM_CONT)
  ) u_tx (
    .clk         (clk),
    .rst         (rst),
    .hist_clr    (hist_clr),
    .in_data     (tx_in_data),
    .in_k        (tx_in_k),
    .fill_word   (fill_word),
    .fill_step   (fill_step),
    .fill_reload (fill_reload),
    .out_data    (tx_out_data),
    .out_k       (tx_out_k)
  );

  rps_rx_expand #(
    .DATA_W  (DATA_W),
    .P_ALIGN (PRIM_ALIGN),
    .P_CONT  (PRIM_CONT),
    .P_HOLD  (PRIM_HOLD),
    .P_IDLE  (PRIM_IDLE)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .in_data  (rx_in_data),
    .in_k     (rx_in_k),
    .hist_clr (hist_clr),
    .out_data (rx_out_data),
    .out_k    (rx_out_k)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!tx_out_k && !rx_out_k)); // R1

endmodule

// File: tb/rpt_prim_squash_tb.sv
`timescale 1ns/1ps
module rpt_prim_squash_tb;
  localparam logic [31:0] P_ALIGN = 32'h7B4A4ABC;
  localparam logic [31:0] P_CONT  = 32'h9999AA7C;
  localparam logic [31:0] P_HOLD  = 32'hD5D5AA7C;
  localparam logic [31:0] P_IDLE  = 32'hB5B5957C;
  localparam logic [31:0] P_RRDY  = 32'h4A4A957C;
  localparam logic [31:0] P_XRDY  = 32'h5757B57C;
  localparam logic [15:0] SEED    = 16'hF0F6;
  localparam int          CW      = 2;
  localparam int          CMAX    = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tx_in_data = '0, rx_in_data = '0;
  logic        tx_in_k = 1'b0, rx_in_k = 1'b0;
  logic [31:0] tx_out_data, rx_out_data;
  logic        tx_out_k, rx_out_k;

  always #10 clk = ~clk;

  rpt_prim_squash #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst),
    .tx_in_data(tx_in_data), .tx_in_k(tx_in_k),
    .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
    .rx_in_data(rx_in_data), .rx_in_k(rx_in_k),
    .rx_out_data(rx_out_data), .rx_out_k(rx_out_k)
  );

  typedef struct {
    logic [31:0] txd; logic txk; string txr;
    logic [31:0] rxd; logic rxk; string rxr;
  } exp_t;
  exp_t scb[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  logic [31:0] m_h0 = '0, m_h1 = '0;
  logic        m_h0v = 1'b0, m_h1v = 1'b0;
  int          m_cnt = 0;
  logic [15:0] m_lfsr = SEED;
  logic        m_flag = 1'b0;
  logic [31:0] m_last = P_IDLE;

  function automatic logic [31:0] gen_word(input logic [15:0] s0);
    logic [15:0] s = s0;
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) begin
      w[i] = s[15];
      s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    end
    return w;
  endfunction

  function automatic logic [15:0] gen_next(input logic [15:0] s0);
    logic [15:0] s = s0;
    for (int i = 0; i < 32; i++) s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    return s;
  endfunction

  task automatic check(input string r, input string what,
                       input logic [31:0] ad, input logic ak,
                       input logic [31:0] ed, input logic ek);
    n_cmp++;
    if (ad !== ed || ak !== ek) begin
      n_bad++;
      $display("FAIL %s %s: actual %h/k%0b expected %h/k%0b", r, what, ad, ak, ed, ek);
    end
  endtask

  task automatic drive(input logic [31:0] td, input logic tk,
                       input logic [31:0] rd, input logic rk);
    exp_t e;
    logic clr, cnt_ok, run;
    @(negedge clk);
    tx_in_data = td; tx_in_k = tk; rx_in_data = rd; rx_in_k = rk;
    // receive model (R6..R10)
    clr = m_flag && rk && (rd == P_HOLD);
    if (rk && rd == P_CONT) begin
      e.rxd = m_last; e.rxk = 1'b1; e.rxr = "R7"; m_flag = 1'b1;
    end else if (rk && rd == P_ALIGN) begin
      e.rxd = rd; e.rxk = 1'b1; e.rxr = "R8";
    end else if (rk) begin
      e.rxd = rd; e.rxk = 1'b1; e.rxr = "R6"; m_flag = 1'b0; m_last = rd;
    end else if (m_flag) begin
      e.rxd = m_last; e.rxk = 1'b1; e.rxr = "R7";
    end else begin
      e.rxd = rd; e.rxk = 1'b0; e.rxr = "R9";
    end
    // transmit model (R2..R5, R10, R11)
    cnt_ok = tk && (td != P_ALIGN);
    run = cnt_ok && m_h0v && m_h1v && !clr && m_h0 == td && m_h1 == td;
    if (!run) begin
      e.txd = td; e.txk = tk;
      if (clr)          e.txr = "R10";
      else if (!cnt_ok) e.txr = "R2";
      else if (m_cnt != 0) e.txr = "R5";
      else              e.txr = "R3";
      m_cnt = 0; m_lfsr = SEED;
    end else if (m_cnt == 0) begin
      e.txd = P_CONT; e.txk = 1'b1; e.txr = "R3"; m_cnt = 1;
    end else begin
      e.txd = gen_word(m_lfsr); e.txk = 1'b0;
      e.txr = (m_cnt == CMAX) ? "R11" : "R4";
      m_lfsr = gen_next(m_lfsr);
      if (m_cnt < CMAX) m_cnt++;
    end
    m_h1 = m_h0; m_h1v = m_h0v && !clr;
    m_h0 = td;   m_h0v = cnt_ok;
    scb.push_back(e);
  endtask

  // Monitor: one result per cycle, sampled 2 ns after the rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (!rst && scb.size() > 0) begin
        e = scb.pop_front();
        check(e.txr, "tx", tx_out_data, tx_out_k, e.txd, e.txk);
        check(e.rxr, "rx", rx_out_data, rx_out_k, e.rxd, e.rxk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rseq [8];
    logic        rkseq[8];
    repeat (3) @(negedge clk);
    check("R1", "tx reset", tx_out_data, tx_out_k, 32'h0, 1'b0);
    check("R1", "rx reset", rx_out_data, rx_out_k, 32'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;   // idle data 0 flows for one cycle before stimulus

    // R7: CONT before any primitive replays the idle primitive; R6, R9
    drive(32'h11111111, 0, P_CONT, 1);
    drive(32'h22222222, 0, 32'hAAAA0000, 0);
    drive(32'h33333333, 0, P_RRDY, 1);
    drive(32'h44444444, 0, 32'h12345678, 0);
    for (int i = 0; i < 4; i++) drive(32'h0F0F0000 + i, 0, 32'hC0DE0000 + i, 0);

    // R3, R4, R11: nine copies with a 2-bit counter
    for (int i = 0; i < 9; i++) drive(P_IDLE, 1, 32'h0, 0);
    // R5: break by data, then a new run restarts at CONT and the seed
    drive(32'hDEADBEEF, 0, 32'h0, 0);
    for (int i = 0; i < 5; i++) drive(P_IDLE, 1, 32'h0, 0);
    drive(P_XRDY, 1, 32'h0, 0);   // different primitive breaks
    drive(P_XRDY, 1, 32'h0, 0);

    // R2: ALIGN never forms a run and splits runs
    for (int i = 0; i < 4; i++) drive(P_ALIGN, 1, 32'h0, 0);
    drive(P_XRDY, 1, 32'h0, 0);
    drive(P_ALIGN, 1, 32'h0, 0);
    for (int i = 0; i < 4; i++) drive(P_XRDY, 1, 32'h0, 0);

    // R6, R7, R8, R9 on receive
    drive(32'h1, 0, P_RRDY, 1);
    drive(32'h2, 0, P_CONT, 1);
    drive(32'h3, 0, 32'h5A5A5A5A, 0);
    drive(32'h4, 0, P_ALIGN, 1);
    drive(32'h5, 0, 32'hA5A5A5A5, 0);
    drive(32'h6, 0, 32'h01020304, 0);
    drive(32'h7, 0, P_XRDY, 1);
    drive(32'h8, 0, 32'h99990000, 0);

    // R10: HOLD with the flag set, in the middle of a transmit run
    rseq  = '{P_XRDY, P_CONT, 32'h0, 32'h0, P_HOLD, 32'h0, 32'h0, 32'h0};
    rkseq = '{1, 1, 0, 0, 1, 0, 0, 0};
    for (int i = 0; i < 8; i++) drive(P_IDLE, 1, rseq[i], rkseq[i]);
    // HOLD with the flag clear: run continues (R10)
    drive(32'h0, 0, 32'h0, 0);
    rseq  = '{P_RRDY, 32'h0, 32'h0, 32'h0, P_HOLD, 32'h0, 32'h0, 32'h0};
    rkseq = '{1, 0, 0, 0, 1, 0, 0, 0};
    for (int i = 0; i < 8; i++) drive(P_RRDY, 1, rseq[i], rkseq[i]);
    // HOLD at the CONT cycle of a fresh run (R10)
    drive(32'h0, 0, P_CONT, 1);
    drive(P_HOLD, 1, 32'h0, 0);
    drive(P_HOLD, 1, 32'h0, 0);
    drive(P_HOLD, 1, P_HOLD, 1);
    drive(P_HOLD, 1, 32'h0, 0);
    drive(P_HOLD, 1, 32'h0, 0);
    drive(P_HOLD, 1, 32'h0, 0);

    drive(32'h0, 0, 32'h0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule